// File: doc/BRIEF.md
# Coefficient Reconstruction Stage with Saturation

This block turns quantized transform levels back into transform coefficients with the same arithmetic a receiving decoder uses. The local reconstruction loop of a video encoder needs this so that its reference picture matches the receiver's copy bit for bit. Each input carries a signed level, a 5-bit quantizer code and a flag that marks the DC term of an intra-coded block. Each output carries a 12-bit two's-complement coefficient.

For ordinary coefficients the step size is twice the code value. The rounding offset depends on whether the code is odd or even. The DC term of an intra block uses its own rule: the level is read as unsigned and scaled by eight, and the all-ones level is an escape that stands for 1024. Every result is saturated to the 12-bit signed range.

The stage takes one coefficient per clock. A result appears two clocks after it is presented, and back-to-back inputs are accepted.

Top module: `iq_recon`

## Requirements
- R1: While reset (`rstN` low) is asserted, and after it is released until the first result, `outValid` is 0 and `outCoef` is 0. Reset takes effect at once, even with data in flight.
- R2: A sample presented with `inValid` high at a rising clock edge produces `outValid` high for exactly one cycle, two rising edges later. Consecutive samples give consecutive results with no gaps.
- R3: For a non-DC input with an odd code Q, a level L > 0 gives Q*(2L+1) and a level L < 0 gives Q*(2L-1). The level is 8-bit two's complement. Example: L=5, Q=7 gives 77.
- R4: For a non-DC input with an even, non-zero code Q, a level L > 0 gives Q*(2L+1)-1 and a level L < 0 gives Q*(2L-1)+1. Example: L=10, Q=16 gives 335.
- R5: A non-DC input with level 0 gives 0 for every code.
- R6: When `inIntraDc` is 1, the level is read as unsigned (0 to 254) and the result is 8 times the level. `inQuant` has no effect in this case. Example: level 128 gives 1024.
- R7: When `inIntraDc` is 1 and the level is 255 (all ones), the result is 1024.
- R8: Any result above +2047 is output as +2047, and any result below -2048 is output as -2048.
- R9: A non-DC input with quantizer code 0 gives 0.
- R10: While no new result is delivered (`outValid` low), `outCoef` keeps the last delivered value, whatever happens at the inputs.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rstN | input | 1 | Asynchronous reset, active low |
| inValid | input | 1 | Marks the current input sample as valid |
| inLevel | input | 8 | Quantized level: signed for non-DC, unsigned for intra DC |
| inQuant | input | 5 | Quantizer code; the step size is twice this value |
| inIntraDc | input | 1 | 1 selects the intra DC reconstruction rule |
| outValid | output | 1 | Marks `outCoef` as a new result |
| outCoef | output | 12 | Reconstructed coefficient, two's complement |

## Verification
The bench streams both code parities with positive and negative levels, alongside values just below and just above the saturation limits. A design that used one rounding rule for every code parity would be off by one on even codes. A design missing saturation would wrap large products around to the wrong sign.

Intra DC levels of 128 and 254 expose a design that sign-extends the DC level, which would turn those results negative. The all-ones escape exposes a design that computes 8*255=2040 instead of 1024.

Code-zero inputs, isolated samples, idle stretches with changing inputs, and a reset with data in flight catch a wrong latency, a valid that is held too long, an output that follows the inputs while idle, and stale data that survives reset.

// File: rtl/iq_pkg.sv
package iq_pkg;
  // Load strobes from the control half to the datapath registers.
  typedef struct packed {
    logic s1Load;   // capture the raw (unclipped) product
    logic s2Load;   // capture the saturated coefficient
  } iqStrobe_t;
endpackage

// File: rtl/iq_ctrl.sv
module iq_ctrl
  import iq_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       inValid,
  output iqStrobe_t  strobe,
  output logic       outValid
);
  logic v1;
  logic v2;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      v1 <= 1'b0;
      v2 <= 1'b0;
    end else begin
      v1 <= inValid;
      v2 <= v1;
    end
  end

  always_comb begin
    strobe.s1Load = inValid;
    strobe.s2Load = v1;
  end

  assign outValid = v2;
endmodule

// File: rtl/iq_datapath.sv
module iq_datapath
  import iq_pkg::*;
#(
  parameter int LEVEL_W = 8,
  parameter int QUANT_W = 5,
  parameter int COEF_W  = 12,
  parameter int DC_ESC  = 1024
) (
  input  logic               clk,
  input  logic               rstN,
  input  iqStrobe_t          strobe,
  input  logic [LEVEL_W-1:0] inLevel,
  input  logic [QUANT_W-1:0] inQuant,
  input  logic               inIntraDc,
  output logic [COEF_W-1:0]  outCoef
);
  // Wide enough for code * (2*level +/- 1) with sign.
  localparam int RAW_W = LEVEL_W + QUANT_W + 3;
  localparam logic signed [RAW_W-1:0] ONE      = 1;
  localparam logic signed [RAW_W-1:0] COEF_MAX = (1 <<< (COEF_W - 1)) - 1;
  localparam logic signed [RAW_W-1:0] COEF_MIN = -COEF_MAX - ONE;
  localparam logic signed [RAW_W-1:0] ESC_VAL  = DC_ESC;

  logic signed [RAW_W-1:0] lvlS, lvlU, qS, evenAdj;
  logic signed [RAW_W-1:0] posTerm, negTerm, rawNext, rawQ, clipped;
  logic [COEF_W-1:0]       coefQ;

  // Stage 1: apply the parity-dependent reconstruction rule.
  always_comb begin
    lvlS    = {{(RAW_W-LEVEL_W){inLevel[LEVEL_W-1]}}, inLevel};
    lvlU    = {{(RAW_W-LEVEL_W){1'b0}}, inLevel};
    qS      = {{(RAW_W-QUANT_W){1'b0}}, inQuant};
    evenAdj = {{(RAW_W-1){1'b0}}, ~inQuant[0]};
    posTerm = (lvlS <<< 1) + ONE;
    negTerm = (lvlS <<< 1) - ONE;
    if (inIntraDc) begin
      rawNext = (&inLevel) ? ESC_VAL : (lvlU <<< 3);
    end else if ((inLevel == '0) || (inQuant == '0)) begin
      rawNext = '0;
    end else if (!inLevel[LEVEL_W-1]) begin
      rawNext = (qS * posTerm) - evenAdj;
    end else begin
      rawNext = (qS * negTerm) + evenAdj;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)              rawQ <= '0;
    else if (strobe.s1Load) rawQ <= rawNext;
  end

  // Stage 2: saturate to the output range.
  always_comb begin
    if (rawQ > COEF_MAX)      clipped = COEF_MAX;
    else if (rawQ < COEF_MIN) clipped = COEF_MIN;
    else                      clipped = rawQ;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)              coefQ <= '0;
    else if (strobe.s2Load) coefQ <= clipped[COEF_W-1:0];
  end

  assign outCoef = coefQ;
endmodule

// File: rtl/iq_recon.sv
module iq_recon
  import iq_pkg::*;
#(
  parameter int LEVEL_W = 8,
  parameter int QUANT_W = 5,
  parameter int COEF_W  = 12,
  parameter int DC_ESC  = 1024
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               inValid,
  input  logic [LEVEL_W-1:0] inLevel,
  input  logic [QUANT_W-1:0] inQuant,
  input  logic               inIntraDc,
  output logic               outValid,
  output logic [COEF_W-1:0]  outCoef
);
  iqStrobe_t strobe;

  iq_ctrl ctrl_i (
    .clk      (clk),
    .rstN     (rstN),
    .inValid  (inValid),
    .strobe   (strobe),
    .outValid (outValid)
  );

  iq_datapath #(
    .LEVEL_W (LEVEL_W),
    .QUANT_W (QUANT_W),
    .COEF_W  (COEF_W),
    .DC_ESC  (DC_ESC)
  ) dp_i (
    .clk       (clk),
    .rstN      (rstN),
    .strobe    (strobe),
    .inLevel   (inLevel),
    .inQuant   (inQuant),
    .inIntraDc (inIntraDc),
    .outCoef   (outCoef)
  );
endmodule

// File: rtl/iq_recon_chk.sv
module iq_recon_chk #(
  parameter int LEVEL_W = 8,
  parameter int QUANT_W = 5,
  parameter int COEF_W  = 12
) (
  input logic               clk,
  input logic               rstN,
  input logic               inValid,
  input logic [LEVEL_W-1:0] inLevel,
  input logic [QUANT_W-1:0] inQuant,
  input logic               inIntraDc,
  input logic               outValid,
  input logic [COEF_W-1:0]  outCoef
);
  // Cycles since reset release, saturating, so $past never reaches into reset.
  logic [1:0] seen;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)             seen <= '0;
    else if (seen != 2'd3) seen <= seen + 2'd1;
  end

  p_latency_r2: assert property (@(posedge clk) disable iff (!rstN)
    (seen >= 2'd2) |-> (outValid == $past(inValid, 2)));

  p_zero_level_r5: assert property (@(posedge clk) disable iff (!rstN)
    (seen >= 2'd2) && $past(inValid, 2) && ($past(inLevel, 2) == '0)
    |-> (outCoef == '0));

  p_zero_code_r9: assert property (@(posedge clk) disable iff (!rstN)
    (seen >= 2'd2) && $past(inValid, 2) && !$past(inIntraDc, 2) && ($past(inQuant, 2) == '0)
    |-> (outCoef == '0));

  p_hold_r10: assert property (@(posedge clk) disable iff (!rstN)
    (seen >= 2'd1) && !outValid |-> $stable(outCoef));

  p_pos_sign_r3: assert property (@(posedge clk) disable iff (!rstN)
    (seen >= 2'd2) && $past(inValid, 2) && !$past(inIntraDc, 2) && ($past(inQuant, 2) != '0)
      && ($signed($past(inLevel, 2)) > 0)
    |-> ($signed(outCoef) > 0));

  p_neg_sign_r4: assert property (@(posedge clk) disable iff (!rstN)
    (seen >= 2'd2) && $past(inValid, 2) && !$past(inIntraDc, 2) && ($past(inQuant, 2) != '0)
      && ($signed($past(inLevel, 2)) < 0)
    |-> ($signed(outCoef) < 0));

  // R3 and R4: both parity rules yield odd magnitudes unless saturated at the negative limit.
  p_odd_result_r3: assert property (@(posedge clk) disable iff (!rstN)
    (seen >= 2'd2) && $past(inValid, 2) && !$past(inIntraDc, 2) && ($past(inQuant, 2) != '0)
      && ($past(inLevel, 2) != '0)
    |-> (outCoef[0] || (outCoef == {1'b1, {(COEF_W-1){1'b0}}})));

  p_dc_nonneg_r6: assert property (@(posedge clk) disable iff (!rstN)
    (seen >= 2'd2) && $past(inValid, 2) && $past(inIntraDc, 2)
    |-> !outCoef[COEF_W-1]);
endmodule

bind iq_recon iq_recon_chk #(
  .LEVEL_W (LEVEL_W),
  .QUANT_W (QUANT_W),
  .COEF_W  (COEF_W)
) chk_i (
  .clk       (clk),
  .rstN      (rstN),
  .inValid   (inValid),
  .inLevel   (inLevel),
  .inQuant   (inQuant),
  .inIntraDc (inIntraDc),
  .outValid  (outValid),
  .outCoef   (outCoef)
);

// File: tb/iq_recon_tb_top.sv
module iq_recon_tb_top;
  logic       clk = 1'b0;
  logic       rstN;
  logic       inValid;
  logic [7:0] inLevel;
  logic [4:0] inQuant;
  logic       inIntraDc;
  logic       outValid;
  logic [11:0] outCoef;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  always #10 clk = ~clk;   // 50 MHz

  iq_recon dut_i (
    .clk       (clk),
    .rstN      (rstN),
    .inValid   (inValid),
    .inLevel   (inLevel),
    .inQuant   (inQuant),
    .inIntraDc (inIntraDc),
    .outValid  (outValid),
    .outCoef   (outCoef)
  );

  typedef struct packed {
    logic        dc;
    logic [7:0]  lvl;
    logic [4:0]  q;
    logic [11:0] exp;
    logic [3:0]  req;
  } vec_t;

  localparam int NV = 27;
  localparam vec_t VEC [0:NV-1] = '{
    '{1'b0,   8'd1,  5'd1,     12'd3, 4'd3},
    '{1'b0, -8'sd1,  5'd1,   -12'sd3, 4'd3},
    '{1'b0,   8'd5,  5'd7,    12'd77, 4'd3},
    '{1'b0, -8'sd5,  5'd7,  -12'sd77, 4'd3},
    '{1'b0,-8'sd128, 5'd1, -12'sd257, 4'd3},
    '{1'b0,  8'd32,  5'd31, 12'd2015, 4'd3},
    '{1'b0,   8'd1,  5'd2,     12'd5, 4'd4},
    '{1'b0, -8'sd1,  5'd2,   -12'sd5, 4'd4},
    '{1'b0,  8'd10,  5'd16,  12'd335, 4'd4},
    '{1'b0,-8'sd10,  5'd16,-12'sd335, 4'd4},
    '{1'b0, 8'd127,  5'd2,   12'd509, 4'd4},
    '{1'b0,  8'd33,  5'd30, 12'd2009, 4'd4},
    '{1'b0,   8'd0,  5'd9,     12'd0, 4'd5},
    '{1'b0,   8'd0,  5'd30,    12'd0, 4'd5},
    '{1'b1,   8'd1,  5'd0,     12'd8, 4'd6},
    '{1'b1, 8'd128,  5'd0,  12'd1024, 4'd6},
    '{1'b1, 8'd254,  5'd0,  12'd2032, 4'd6},
    '{1'b1, 8'd255,  5'd0,  12'd1024, 4'd7},
    '{1'b1,   8'd0,  5'd0,     12'd0, 4'd6},
    '{1'b0, 8'd127,  5'd31, 12'd2047, 4'd8},
    '{1'b0,-8'sd128, 5'd31,-12'sd2048,4'd8},
    '{1'b0,  8'd33,  5'd31, 12'd2047, 4'd8},
    '{1'b0,-8'sd33,  5'd31,-12'sd2048,4'd8},
    '{1'b0,  8'd34,  5'd30, 12'd2047, 4'd8},
    '{1'b0,   8'd5,  5'd0,     12'd0, 4'd9},
    '{1'b0, -8'sd7,  5'd0,     12'd0, 4'd9},
    '{1'b1, 8'd255,  5'd17, 12'd1024, 4'd6}
  };

  function automatic string reqName(logic [3:0] n);
    case (n)
      4'd3:    return "R3";
      4'd4:    return "R4";
      4'd5:    return "R5";
      4'd6:    return "R6";
      4'd7:    return "R7";
      4'd8:    return "R8";
      default: return "R9";
    endcase
  endfunction

  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic drive(logic v, logic dc, logic [7:0] l, logic [4:0] q);
    inValid   = v;
    inIntraDc = dc;
    inLevel   = l;
    inQuant   = q;
  endtask

  initial begin
    rstN = 1'b0;
    drive(1'b0, 1'b0, 8'd0, 5'd0);
    repeat (3) @(negedge clk);
    check("R1", int'(outValid), 0);
    check("R1", $signed(outCoef), 0);
    rstN = 1'b1;
    @(negedge clk);
    check("R1", int'(outValid), 0);
    check("R1", $signed(outCoef), 0);

    // Back-to-back stream through the vector table.
    for (int t = 0; t < NV + 2; t++) begin
      if (t >= 2) begin
        check("R2", int'(outValid), 1);
        check(reqName(VEC[t-2].req), $signed(outCoef), $signed(VEC[t-2].exp));
      end
      if (t < NV) drive(1'b1, VEC[t].dc, VEC[t].lvl, VEC[t].q);
      else        drive(1'b0, 1'b0, 8'h5A + 8'(t), 5'd3);
      @(negedge clk);
    end
    check("R2", int'(outValid), 0);
    check("R10", $signed(outCoef), $signed(VEC[NV-1].exp));

    // Idle with changing inputs: output must hold.
    for (int k = 0; k < 4; k++) begin
      drive(1'b0, k[0], 8'h81 + 8'(k * 37), 5'(k + 7));
      @(negedge clk);
      check("R10", $signed(outCoef), $signed(VEC[NV-1].exp));
      check("R2", int'(outValid), 0);
    end

    // Isolated sample: 5*(2*3+1)=35.
    drive(1'b1, 1'b0, 8'd3, 5'd5);
    @(negedge clk);
    drive(1'b0, 1'b0, 8'd0, 5'd0);
    check("R2", int'(outValid), 0);
    @(negedge clk);
    check("R2", int'(outValid), 1);
    check("R3", $signed(outCoef), 35);
    @(negedge clk);
    check("R2", int'(outValid), 0);
    check("R10", $signed(outCoef), 35);

    // Reset with data in flight: 4*(2*9+1)-1=75 must never appear.
    drive(1'b1, 1'b0, 8'd9, 5'd4);
    @(negedge clk);
    drive(1'b0, 1'b0, 8'd0, 5'd0);
    rstN = 1'b0;
    #1;
    check("R1", int'(outValid), 0);
    check("R1", $signed(outCoef), 0);
    @(negedge clk);
    check("R1", int'(outValid), 0);
    check("R1", $signed(outCoef), 0);
    rstN = 1'b1;
    @(negedge clk);
    check("R1", int'(outValid), 0);

    // Alive after reset: 3*(2*-2-1)=-15.
    drive(1'b1, 1'b0, -8'sd2, 5'd3);
    @(negedge clk);
    drive(1'b0, 1'b0, 8'd0, 5'd0);
    @(negedge clk);
    check("R2", int'(outValid), 1);
    check("R3", $signed(outCoef), -15);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired before the run completed");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule